// File: doc/BRIEF.md
# RGMII Receive DDR Nibble Deserializer

This block sits right after the input capture cells of a reduced-pin gigabit Ethernet receive port. For each cycle of the receive clock sent by the PHY it takes four values: the data nibble captured on the rising edge, the data nibble captured on the falling edge, and the control line as captured on each of the two edges. From these it builds one byte per cycle and decodes the control line into a data-valid flag and a receive-error flag. It also marks the first byte of every frame with a one-cycle start pulse.

The receive clock runs at 2.5, 25 or 125 MHz, for 10, 100 and 1000 Mbps. Everything here is in that clock domain. The outputs are registered, so each result appears one cycle after its inputs are sampled. The error condition is never sent on its own wire. The block recovers it by comparing the control sample from the falling edge with the valid sample from the rising edge. It reports the error only while valid is high.

Top module: `rgmii_rx_deser`

## Requirements
- R1: One clock after a cycle in which the rising-edge control sample is 1, `rx_byte_o` holds the falling-edge nibble in bits 7:4 and the rising-edge nibble in bits 3:0. Bit 0 of each nibble is its least-significant bit.
- R2: `rx_valid_o` equals the rising-edge control sample of the previous clock.
- R3: Control encoding is (rise, fall). (1,1) is a good data byte, (1,0) is a byte with a receive error, and (0,0) is idle. `rx_err_o` equals valid XOR the falling-edge sample while valid is 1, with the same one-clock latency as R2.
- R4: When the rising-edge control sample is 0, `rx_err_o` is 0 one clock later, whatever the falling-edge sample is.
- R5: When the rising-edge control sample is 0, `rx_byte_o` keeps its previous value one clock later. Data nibbles given in that cycle have no effect.
- R6: `rx_sof_o` is 1 for exactly one clock, on the first valid cycle after a cycle in which valid was 0. The cycle right after reset counts as not valid.
- R7: `rx_sof_o` stays 0 on every later valid cycle of the same frame. A frame that follows a single idle cycle gets a new start pulse.
- R8: While reset is asserted, `rx_byte_o`, `rx_valid_o`, `rx_err_o` and `rx_sof_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_nib_rise_i | input | NIB_W | Data nibble captured on the rising edge |
| rx_nib_fall_i | input | NIB_W | Data nibble captured on the falling edge |
| rx_ctl_rise_i | input | 1 | Control line captured on the rising edge (data valid) |
| rx_ctl_fall_i | input | 1 | Control line captured on the falling edge |
| rx_byte_o | output | 2*NIB_W | Reassembled byte |
| rx_valid_o | output | 1 | Byte valid |
| rx_err_o | output | 1 | Receive error for the current byte |
| rx_sof_o | output | 1 | One-cycle pulse on the first byte of a frame |

## Verification
The bench builds the block with its default nibble width of 4, which is the width the PHY bus uses. This puts the full 256-value byte space within reach, so random nibble pairs can show a swap of the two nibbles or a bit-order error. It covers every one of the four control pairs, including the "falling high while not valid" pair that must not raise an error. The frame sequences include frames that start straight out of reset, frames separated by a single idle cycle, and frames that open with an errored byte. These exercise the start-pulse edge detection at its tightest spacing.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;

  typedef struct packed {
    logic valid;
    logic err;
  } rx_flags_t;

  // Rising sample is data valid; the error is valid XOR the falling sample,
  // and it is suppressed while valid is low.
  function automatic rx_flags_t decode_ctl(input logic ctl_rise, input logic ctl_fall);
    rx_flags_t f;
    f.valid = ctl_rise;
    f.err   = ctl_rise & (ctl_rise ^ ctl_fall);
    return f;
  endfunction

  // Start of frame: valid now, not valid in the cycle before.
  function automatic logic frame_start(input logic valid_now, input logic valid_before);
    return valid_now & ~valid_before;
  endfunction

endpackage

// File: rtl/rgrx_nibble_join.sv
module rgrx_nibble_join #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic [NIB_W-1:0]   nib_lo_i,
  input  logic [NIB_W-1:0]   nib_hi_i,
  output logic [2*NIB_W-1:0] byte_o
);
  localparam int BYTE_W = 2 * NIB_W;

  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] lo,
                                                     input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction

  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         byte_q <= '0;
    else if (capture_i) byte_q <= join_nibbles(nib_lo_i, nib_hi_i);
  end

  assign byte_o = byte_q;

  // R1: rising nibble lands in the low half, falling nibble in the high half
  a_r1_nibble_order: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (byte_o[NIB_W-1:0] == $past(nib_lo_i)) &&
                  (byte_o[BYTE_W-1:NIB_W] == $past(nib_hi_i)));

  // R5: byte is held while not valid
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(byte_o));

endmodule

// File: rtl/rgrx_ctl_decode.sv
module rgrx_ctl_decode
  import rgmii_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_rise_i,
  input  logic ctl_fall_i,
  output logic valid_o,
  output logic err_o
);
  rx_flags_t flags_d;
  rx_flags_t flags_q;

  assign flags_d = decode_ctl(ctl_rise_i, ctl_fall_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign valid_o = flags_q.valid;
  assign err_o   = flags_q.err;

  // R2: valid follows the rising control sample by one clock
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> valid_o == $past(ctl_rise_i));

  // R3: rising high with falling low flags an error
  a_r3_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rise_i && !ctl_fall_i) |=> err_o);

  // R3: rising high with falling high is clean data
  a_r3_good_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rise_i && ctl_fall_i) |=> !err_o);

  // R4: no error is reported outside valid
  a_r4_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);

endmodule

// File: rtl/rgrx_frame_mark.sv
module rgrx_frame_mark
  import rgmii_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_now_i,
  input  logic valid_prev_i,
  output logic sof_o
);
  logic sof_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_q <= 1'b0;
    else        sof_q <= frame_start(valid_now_i, valid_prev_i);
  end

  assign sof_o = sof_q;

  // R6: the start pulse never lasts two clocks
  a_r6_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |=> !sof_o);

endmodule

// File: rtl/rgmii_rx_deser.sv
module rgmii_rx_deser #(
  parameter int NIB_W = 4
) (
  input  logic               clk_rx,
  input  logic               rst_n,
  input  logic [NIB_W-1:0]   rx_nib_rise_i,
  input  logic [NIB_W-1:0]   rx_nib_fall_i,
  input  logic               rx_ctl_rise_i,
  input  logic               rx_ctl_fall_i,
  output logic [2*NIB_W-1:0] rx_byte_o,
  output logic               rx_valid_o,
  output logic               rx_err_o,
  output logic               rx_sof_o
);
  logic valid_q;
  logic err_q;
  logic sof_q;
  logic [2*NIB_W-1:0] byte_q;

  rgrx_nibble_join #(.NIB_W(NIB_W)) u_join (
    .clk       (clk_rx),
    .rst_n     (rst_n),
    .capture_i (rx_ctl_rise_i),
    .nib_lo_i  (rx_nib_rise_i),
    .nib_hi_i  (rx_nib_fall_i),
    .byte_o    (byte_q)
  );

  rgrx_ctl_decode u_ctl (
    .clk        (clk_rx),
    .rst_n      (rst_n),
    .ctl_rise_i (rx_ctl_rise_i),
    .ctl_fall_i (rx_ctl_fall_i),
    .valid_o    (valid_q),
    .err_o      (err_q)
  );

  rgrx_frame_mark u_mark (
    .clk          (clk_rx),
    .rst_n        (rst_n),
    .valid_now_i  (rx_ctl_rise_i),
    .valid_prev_i (valid_q),
    .sof_o        (sof_q)
  );

  assign rx_byte_o  = byte_q;
  assign rx_valid_o = valid_q;
  assign rx_err_o   = err_q;
  assign rx_sof_o   = sof_q;

  // R6: a start pulse only comes with a valid byte
  a_r6_sof_with_valid: assert property (@(posedge clk_rx) disable iff (!rst_n)
    rx_sof_o |-> rx_valid_o);

  // R7: a start pulse only follows a cycle without valid
  a_r7_sof_after_gap: assert property (@(posedge clk_rx) disable iff (!rst_n)
    rx_sof_o |-> !$past(rx_valid_o));

  // R7: every valid cycle after an idle one carries the start pulse
  a_r7_gap_then_sof: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (rx_valid_o && !$past(rx_valid_o)) |-> rx_sof_o);

  // R8: outputs are clear while reset is held
  a_r8_reset_clear: assert property (@(posedge clk_rx)
    !rst_n |-> (rx_byte_o == '0) && !rx_valid_o && !rx_err_o && !rx_sof_o);

endmodule

// File: tb/test_rgmii_rx_deser.sv
module test_rgmii_rx_deser;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef struct {
    logic [BYTE_W-1:0] data;
    logic              valid;
    logic              err;
    logic              sof;
  } exp_t;

  logic               clk_rx = 1'b0;
  logic               rst_n  = 1'b0;
  logic [NIB_W-1:0]   nib_r  = '0;
  logic [NIB_W-1:0]   nib_f  = '0;
  logic               ctl_r  = 1'b0;
  logic               ctl_f  = 1'b0;
  logic [BYTE_W-1:0]  byte_o;
  logic               valid_o, err_o, sof_o;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  exp_t sb_q[$];

  // bench-side model state
  logic [BYTE_W-1:0] m_byte = '0;
  logic              m_prev = 1'b0;

  always #4 clk_rx = ~clk_rx;  // 125 MHz

  rgmii_rx_deser #(.NIB_W(NIB_W)) i_rgmii_rx_deser (
    .clk_rx        (clk_rx),
    .rst_n         (rst_n),
    .rx_nib_rise_i (nib_r),
    .rx_nib_fall_i (nib_f),
    .rx_ctl_rise_i (ctl_r),
    .rx_ctl_fall_i (ctl_f),
    .rx_byte_o     (byte_o),
    .rx_valid_o    (valid_o),
    .rx_err_o      (err_o),
    .rx_sof_o      (sof_o)
  );

  // Driver: applies one cycle at a falling edge and pushes the expectation.
  task automatic drive(input logic [NIB_W-1:0] lo, input logic [NIB_W-1:0] hi,
                       input logic cr, input logic cf);
    exp_t e;
    @(negedge clk_rx);
    nib_r = lo; nib_f = hi; ctl_r = cr; ctl_f = cf;
    if (cr) m_byte = {hi, lo};
    e.data  = m_byte;
    e.valid = cr;
    e.err   = (cr == 1'b1) && (cf == 1'b0);
    e.sof   = cr && (m_prev == 1'b0);
    m_prev  = cr;
    sb_q.push_back(e);
  endtask

  task automatic frame(input int len, input int err_at);
    for (int k = 0; k < len; k++)
      drive(4'($urandom), 4'($urandom), 1'b1, (k == err_at) ? 1'b0 : 1'b1);
  endtask

  task automatic idle(input int n, input logic fall_lvl);
    for (int k = 0; k < n; k++)
      drive(4'($urandom), 4'($urandom), 1'b0, fall_lvl);
  endtask

  // Monitor: samples mid-high phase after each rising edge.
  initial begin
    forever begin
      @(posedge clk_rx);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (byte_o !== e.data) begin
          n_fail++;
          $display("FAIL %s byte: got %h expected %h", e.valid ? "R1" : "R5", byte_o, e.data);
        end
        if (valid_o !== e.valid) begin
          n_fail++;
          $display("FAIL R2 valid: got %b expected %b", valid_o, e.valid);
        end
        if (err_o !== e.err) begin
          n_fail++;
          $display("FAIL %s err: got %b expected %b", e.valid ? "R3" : "R4", err_o, e.err);
        end
        if (sof_o !== e.sof) begin
          n_fail++;
          $display("FAIL %s sof: got %b expected %b", e.sof ? "R6" : "R7", sof_o, e.sof);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk_rx);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state, with inputs active while reset is held
    nib_r = 4'hA; nib_f = 4'h5; ctl_r = 1'b1; ctl_f = 1'b1;
    repeat (3) @(posedge clk_rx);
    #2;
    n_vec++;
    if (byte_o !== '0 || valid_o !== 1'b0 || err_o !== 1'b0 || sof_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: got %h/%b/%b/%b expected 00/0/0/0", byte_o, valid_o, err_o, sof_o);
    end
    @(negedge clk_rx);
    ctl_r = 1'b0; ctl_f = 1'b0;
    rst_n = 1'b1;

    // R6: frame right after reset, R1 fixed patterns for nibble order
    drive(4'h1, 4'h8, 1'b1, 1'b1);
    drive(4'hF, 4'h0, 1'b1, 1'b1);
    drive(4'h0, 4'hF, 1'b1, 1'b1);
    drive(4'h5, 4'hA, 1'b1, 1'b1);
    // R5: idle with changing data; R4: falling high while not valid
    idle(3, 1'b0);
    idle(3, 1'b1);
    // R3: error on first byte, then mid-frame, then last byte
    frame(4, 0);
    idle(1, 1'b0);
    frame(6, 3);
    idle(2, 1'b1);
    frame(5, 4);
    // R7: back-to-back frames with one idle cycle between
    for (int f = 0; f < 8; f++) begin
      frame(1 + (f % 4), -1);
      idle(1, f[0]);
    end
    // random mix of all control pairs
    for (int k = 0; k < 400; k++)
      drive(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
    // long frame then drain
    frame(60, 30);
    idle(4, 1'b0);

    wait (sb_q.size() == 0);
    @(posedge clk_rx);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule